// File: doc/BRIEF.md
# Command-Word MDIO Management Master

This block drives a two-wire management bus toward external Ethernet PHYs. Software controls it through a single 32-bit command/status word. One write to that word, with the busy and enable bits both set, carries everything a transfer needs: the operation (read or write), the 5-bit PHY address, the 5-bit register number and, for a write, the 16-bit data. The block then sends one Clause 22 management frame. Software polls the same word until the busy bit drops. After a read, the low 16 bits of the word hold the value the PHY returned.

The management clock (MDC) comes from the system clock through a programmable divider. MDC stays low while nothing is being transferred. The outgoing data line changes only while MDC is low. The block provides the line's output value and its output enable, which feed an external tri-state pad. Incoming data is sampled on rising MDC. A frame with the default settings lasts 512 system clocks. At 200 MHz that is about 2.6 µs, well inside the 20 µs budget that software allows for one transfer.

Top module: `mdio_cmd_master`

## Requirements
- R1: After synchronous reset, the command word reads as all zeros, MDC is low and the data-line output enable is low.
- R2: When the block is idle, a write with bit 31 (busy) and bit 30 (enable) both set starts a frame. From the next cycle the word reads back busy=1, enable at bit 30, operation at bit 27 (1 = read, 0 = write), PHY address at [25:21], register number at [20:16] and data at [15:0]. Bits 29, 28 and 26 read as 0.
- R3: When the block is idle, a write with bit 31 or bit 30 clear stores the fields readable under R2 but starts no frame: busy stays 0 and MDC stays low.
- R4: A write to the command word while busy is set has no effect: the word reads back unchanged and the frame in progress continues as it was.
- R5: MDC is low while idle. During a frame it toggles every MDC_HALF system clocks, and the first rising edge comes MDC_HALF clocks after the accepting edge.
- R6: The data-line output changes only at the accepting edge or when MDC falls. It never changes while MDC is high.
- R7: Every frame sends, MSB first: PRE_LEN ones, start pattern 01, opcode (10 for a read, 01 for a write), the 5-bit PHY address and then the 5-bit register number.
- R8: A write frame follows the register number with the turnaround pattern 10 and the 16 data bits, MSB first. The output enable stays high for all 64 bit slots.
- R9: A read frame drops the output enable from the first turnaround bit to the end of the frame. It samples the input on each of the 16 rising MDC edges of the data slots, MSB first. When busy clears, the value appears in bits [15:0].
- R10: Busy clears, and the output enable falls, at the last falling MDC edge. That edge is 2·MDC_HALF·64 system clocks after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word value written |
| cmd_rdata | output | 32 | Current command/status word |
| mdio_i | input | 1 | Data line value seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value to drive |
| mdio_oe | output | 1 | Data line output enable |

## Verification
The accepting edge is the rising edge at which the write strobe is seen. The new word and busy=1 become visible one cycle after it. MDC rises MDC_HALF cycles after it, and each bit slot then lasts 2·MDC_HALF cycles. Busy, and on a read the returned data, change exactly 128·MDC_HALF cycles after the accepting edge. A behavioural model in the bench advances on each rising edge with the same inputs the design sees. Every output is compared with that model half a cycle later, so each result is checked in the cycle it is due. Frame-level checks collect the bit on each MDC rise and measure busy duration in clock counts.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Command word layout (decoded by software; positions are fixed)
  localparam int CW_BUSY  = 31;
  localparam int CW_EN    = 30;
  localparam int CW_RD    = 27;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int PHY_LSB  = 21;
  localparam int REG_LSB  = 16;

  typedef struct packed {
    logic              en;
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == CW'(HALF - 1));
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);
  localparam int TA_IDX    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_IDX  = TA_IDX + 2;
  localparam int FRAME_LEN = DATA_IDX + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int LAST      = FRAME_LEN - 1;

  logic                 active;
  logic                 rd_q;
  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] frame;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     nxt;
  logic [DATA_W-1:0]    rx_q;

  always_comb begin
    frame = {{PRE_LEN{1'b1}}, 2'b01,
             (rd ? 2'b10 : 2'b01),
             phy, regn,
             (rd ? 2'b11 : 2'b10),
             (rd ? {DATA_W{1'b1}} : wdata)};
  end

  assign nxt     = idx + 1'b1;
  assign done    = active && fall_stb && (idx == IDX_W'(LAST));
  assign rx_data = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rx_q    <= '0;
    end else if (start && !active) begin
      active  <= 1'b1;
      rd_q    <= rd;
      shreg   <= frame;
      idx     <= '0;
      mdio_o  <= frame[FRAME_LEN-1];
      mdio_oe <= 1'b1;
      rx_q    <= '0;
    end else if (active) begin
      if (fall_stb) begin
        if (idx == IDX_W'(LAST)) begin
          active  <= 1'b0;
          idx     <= '0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          idx     <= nxt;
          shreg   <= shreg << 1;
          mdio_o  <= shreg[FRAME_LEN-2];
          mdio_oe <= !(rd_q && (nxt >= IDX_W'(TA_IDX)));
        end
      end
      if (rise_stb && rd_q && (idx >= IDX_W'(DATA_IDX)))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
    end
  end

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (active && rd_q && (idx >= IDX_W'(TA_IDX))) |-> !mdio_oe); // R9
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (active && !rd_q) |-> mdio_oe); // R8
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              start,
  output mdio_cmd_t         cmd
);
  logic unused_rsvd;
  assign unused_rsvd = ^{wdata[29:28], wdata[26]};

  assign start = wr && !busy && wdata[CW_BUSY] && wdata[CW_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cmd  <= '0;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        if (cmd.rd) cmd.data <= rx_data;
      end
    end else if (wr) begin
      cmd.en   <= wdata[CW_EN];
      cmd.rd   <= wdata[CW_RD];
      cmd.phy  <= wdata[PHY_LSB +: ADDR_W];
      cmd.regn <= wdata[REG_LSB +: ADDR_W];
      cmd.data <= wdata[DATA_W-1:0];
      busy     <= wdata[CW_BUSY] && wdata[CW_EN];
    end
  end

  AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done)); // R10
  AST_IGNORE_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(cmd)); // R4
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic              busy, start, done, rise_stb, fall_stb;
  logic [DATA_W-1:0] rx_data;
  mdio_cmd_t         cmd;

  mdio_cmd_reg u_reg (
    .clk(clk), .rst(rst), .wr(cmd_wr), .wdata(cmd_wdata),
    .done(done), .rx_data(rx_data),
    .busy(busy), .start(start), .cmd(cmd)
  );

  mdio_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .start(start),
    .rd(cmd_wdata[CW_RD]),
    .phy(cmd_wdata[PHY_LSB +: ADDR_W]),
    .regn(cmd_wdata[REG_LSB +: ADDR_W]),
    .wdata(cmd_wdata[DATA_W-1:0]),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rx_data(rx_data)
  );

  assign cmd_rdata = {busy, cmd.en, 2'b00, cmd.rd, 1'b0,
                      cmd.phy, cmd.regn, cmd.data};

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc); // R5
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R10
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o)); // R6
endmodule

// File: tb/mdio_cmd_master_tb.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb;
  localparam int H    = 4;
  localparam int FL   = 64;
  localparam int FCYC = 2 * H * FL;

  logic        clk = 1'b0, rst = 1'b1, cmd_wr = 1'b0, mdio_i = 1'b1;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;

  always #2.5 clk = ~clk;

  mdio_cmd_master #(.MDC_HALF(H), .PRE_LEN(32)) u_dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdio_i(mdio_i), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int checks = 0, failures = 0, cyc = 0;

  // reference model state
  bit          m_busy, m_en, m_rd;
  logic [4:0]  m_phy, m_reg;
  logic [15:0] m_data, m_rx, phy_val = '0;
  int          m_t;
  logic [63:0] m_frame;
  logic [63:0] cap, cap_oe;
  bit          prev_mdc;
  logic        prev_o;

  function automatic logic [31:0] mkw(bit s, bit en, bit rd, logic [4:0] p,
                                      logic [4:0] r, logic [15:0] d);
    return {s, en, 2'b00, rd, 1'b0, p, r, d};
  endfunction

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] p,
                                            logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_en = 0; m_rd = 0; m_phy = '0; m_reg = '0;
      m_data = '0; m_rx = '0; m_t = 0; m_frame = '0;
    end else if (m_busy) begin
      m_t++;
      if (m_rd && (m_t % (2 * H)) == H && (m_t / (2 * H)) >= 48)
        m_rx = {m_rx[14:0], mdio_i};
      if (m_t == FCYC) begin
        m_busy = 0;
        if (m_rd) m_data = m_rx;
      end
    end else if (cmd_wr) begin
      m_en = cmd_wdata[30]; m_rd = cmd_wdata[27];
      m_phy = cmd_wdata[25:21]; m_reg = cmd_wdata[20:16];
      m_data = cmd_wdata[15:0];
      if (cmd_wdata[31] && cmd_wdata[30]) begin
        m_busy = 1; m_t = 0; m_rx = '0;
        m_frame = exp_frame(m_rd, m_phy, m_reg, m_data);
      end
    end
    if (cyc > 100000) begin
      failures++;
      $display("FAIL R10 watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // per-cycle comparison, capture and PHY stimulus, half a cycle after the edge
  always @(negedge clk) begin
    if (!rst) begin
      automatic int  idx  = m_t / (2 * H);
      automatic bit  e_mdc = m_busy ? (((m_t / H) % 2) == 1) : 1'b0;
      automatic bit  e_oe  = m_busy && !(m_rd && idx >= 46);
      automatic logic [31:0] e_rd = {m_busy, m_en, 2'b00, m_rd, 1'b0,
                                     m_phy, m_reg, m_data};
      check(cmd_rdata == e_rd, "R2 word", 64'(cmd_rdata), 64'(e_rd));
      check(mdc == e_mdc, "R5 mdc", 64'(mdc), 64'(e_mdc));
      check(mdio_oe == e_oe, "R9 oe", 64'(mdio_oe), 64'(e_oe));
      if (e_oe) check(mdio_o == m_frame[63 - idx], "R7 bit",
                      64'(mdio_o), 64'(m_frame[63 - idx]));
      if (mdc && prev_mdc) check(mdio_o == prev_o, "R6 hold",
                                 64'(mdio_o), 64'(prev_o));
      if (mdc && !prev_mdc) begin
        cap    = {cap[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
      end
      if (m_busy && m_rd && idx == 47) mdio_i = 1'b0;
      else if (m_busy && m_rd && idx >= 48) mdio_i = phy_val[15 - (idx - 48)];
      else mdio_i = 1'b1;
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic wr(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] w, input bit mid, output int dur);
    int t0, g;
    logic [31:0] snap;
    wr(w);
    t0 = cyc; cap = '0; cap_oe = '0;
    check(cmd_rdata == w, "R2 start", 64'(cmd_rdata), 64'(w));
    if (mid) begin
      snap = cmd_rdata;
      repeat (100) @(negedge clk);
      wr(mkw(1, 1, ~w[27], 5'h1F, 5'h1F, 16'hFFFF));
      check(cmd_rdata == snap, "R4 ignored", 64'(cmd_rdata), 64'(snap));
    end
    g = 0;
    while (cmd_rdata[31] && g < 5000) begin @(negedge clk); g++; end
    dur = cyc - t0;
  endtask

  initial begin
    int dur;
    bit seen;
    logic [63:0] ef;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_rdata == 32'h0, "R1 word", 64'(cmd_rdata), 64'h0);
    check(!mdc && !mdio_oe, "R1 lines", {mdc, mdio_oe}, 64'h0);

    // R3: no enable, then no busy
    wr(mkw(1, 0, 1, 5'h0A, 5'h15, 16'h1234));
    check(cmd_rdata == mkw(0, 0, 1, 5'h0A, 5'h15, 16'h1234), "R3 stored",
          64'(cmd_rdata), 64'(mkw(0, 0, 1, 5'h0A, 5'h15, 16'h1234)));
    wr(mkw(0, 1, 0, 5'h03, 5'h04, 16'h0055));
    seen = 0;
    repeat (4 * H) begin @(negedge clk); if (mdc || cmd_rdata[31]) seen = 1; end
    check(!seen, "R3 no frame", 64'(seen), 64'h0);

    // write frame with a write while busy
    run_frame(mkw(1, 1, 0, 5'h11, 5'h03, 16'hA5C3), 1, dur);
    ef = exp_frame(0, 5'h11, 5'h03, 16'hA5C3);
    check(dur == FCYC, "R10 duration", 64'(dur), 64'(FCYC));
    check(cap == ef, "R8 write frame", cap, ef);
    check(cap_oe == '1, "R8 drive", cap_oe, '1);
    check(cmd_rdata[15:0] == 16'hA5C3, "R10 data kept",
          64'(cmd_rdata[15:0]), 64'hA5C3);

    // read frames
    phy_val = 16'h3C5A;
    run_frame(mkw(1, 1, 1, 5'h01, 5'h02, 16'h0000), 0, dur);
    ef = exp_frame(1, 5'h01, 5'h02, 16'h0);
    check(dur == FCYC, "R10 duration rd", 64'(dur), 64'(FCYC));
    check(cap[63:18] == ef[63:18], "R7 read header", 64'(cap[63:18]), 64'(ef[63:18]));
    check(cap_oe[17:0] == '0, "R9 release", 64'(cap_oe[17:0]), 64'h0);
    check(cmd_rdata[15:0] == 16'h3C5A, "R9 value", 64'(cmd_rdata[15:0]), 64'h3C5A);

    phy_val = 16'h8001;
    run_frame(mkw(1, 1, 1, 5'h1F, 5'h00, 16'h7777), 0, dur);
    check(cmd_rdata[15:0] == 16'h8001, "R9 value2", 64'(cmd_rdata[15:0]), 64'h8001);
    check(!cmd_rdata[31] && !mdio_oe, "R10 idle", {cmd_rdata[31], mdio_oe}, 64'h0);

    run_frame(mkw(1, 1, 0, 5'h00, 5'h1F, 16'h0000), 0, dur);
    ef = exp_frame(0, 5'h00, 5'h1F, 16'h0000);
    check(cap == ef, "R8 zero frame", cap, ef);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule